// File: doc/BRIEF.md
# Register-Programmed Memory-to-Memory DMA Engine

This block copies data between two regions of a memory-mapped system without CPU involvement. Software programs a source address, a destination address, a byte count and a control word through a small register port, then writes a start bit. A read master fetches beats from the source into a shallow FIFO. A separate write master drains that FIFO toward the destination. Because of the FIFO, reads can run up to a few beats ahead of writes.

Each side can be treated as memory, where the address advances by the beat size, or as a peripheral register, where the address stays fixed. The beat size is chosen per transaction from 1, 2, 4, 8 or 16 bytes. A transaction ends when the byte count is exhausted or, when enabled, on an end-of-packet flag from either the source or the destination. At the end the block records how it stopped and can raise an interrupt. Start addresses must be aligned to the beat size, and the length must be a multiple of it. Data travels as whole bus words, with no lane steering.

Top module: `dma_engine`

## Requirements
- R1: After reset, every register reads zero, irq_o is low, and neither rd_read_o nor wr_write_o is asserted.
- R2: Register offsets on csr_addr_i are 0 = status, 1 = source address, 2 = destination address, 3 = length in bytes, 4 = control. Control bit fields: [2:0] size code, [3] start (write-only, reads 0), [4] interrupt enable, [5] source end-of-packet enable, [6] destination end-of-packet enable, [7] source fixed, [8] destination fixed.
- R3: Size codes 0..4 select beats of 1, 2, 4, 8 and 16 bytes. A memory-mode side starts at its programmed address and advances by the beat size after each accepted beat.
- R4: A side whose fixed bit is set presents the same address on every beat.
- R5: Without end-of-packet, the transaction ends after the write that moves the last of the programmed bytes. The length register drops by the beat size on each accepted write and reads 0 at the end. Status bit 2 (ended by length) is then set.
- R6: With source end-of-packet enabled, the read beat that carries rd_eop_i is the last one read and the last one written. Status bit 3 (ended by end-of-packet) is then set.
- R7: With destination end-of-packet enabled, an accepted write with wr_eop_i high ends the transaction. Data still queued is discarded, and status bit 3 is set.
- R8: An end-of-packet flag from a side whose enable bit is clear has no effect.
- R9: irq_o equals status bit 0 (done) ANDed with the interrupt enable. Writing 1 to status bit 0 clears done and drops irq_o.
- R10: Beats move in order, unchanged. A read is held while rd_waitreq_i is high and is never issued while the FIFO is full. A write is held while wr_waitreq_i is high and is only issued when the FIFO holds data.
- R11: Status bit 1 (busy) is high from start until the transaction ends with the FIFO empty. Writes to the address, length and control registers are ignored while busy.
- R12: A start with length 0 sets done and ended-by-length at once, with no bus cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_addr_i | input | 3 | Register select |
| csr_wr_i | input | 1 | Register write strobe |
| csr_wdata_i | input | 32 | Register write data |
| csr_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request |
| rd_addr_o | output | ADDR_W | Read master byte address |
| rd_read_o | output | 1 | Read request |
| rd_waitreq_i | input | 1 | Read stall from slave |
| rd_data_i | input | DATA_W | Read data, valid when the read is accepted |
| rd_eop_i | input | 1 | Source end-of-packet, sampled with read data |
| wr_addr_o | output | ADDR_W | Write master byte address |
| wr_write_o | output | 1 | Write request |
| wr_waitreq_i | input | 1 | Write stall from slave |
| wr_data_o | output | DATA_W | Write data |
| wr_eop_i | input | 1 | Destination end-of-packet, sampled on an accepted write |

## Verification
Faults in the address generators show up on the first accepted beat after start: the captured destination address or the source-derived data pattern differs. A corrupted FIFO pointer or count appears as duplicated, dropped or reordered beats in the destination log. It can also appear as a wrong beat count when done rises. Errors in the end logic show in the status bits, in the length register readback and in irq_o, which can be read the cycle after the final write. Random stalls on both masters expose any beat that is lost or repeated under backpressure.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    REG_STATUS = 3'd0,
    REG_SRC    = 3'd1,
    REG_DST    = 3'd2,
    REG_LEN    = 3'd3,
    REG_CTRL   = 3'd4
  } csr_sel_e;

  localparam int CB_GO    = 3;
  localparam int CB_IRQ   = 4;
  localparam int CB_SEOP  = 5;
  localparam int CB_DEOP  = 6;
  localparam int CB_SFIX  = 7;
  localparam int CB_DFIX  = 8;

  function automatic logic [4:0] beat_bytes(input logic [2:0] code);
    case (code)
      3'd0:    beat_bytes = 5'd1;
      3'd1:    beat_bytes = 5'd2;
      3'd2:    beat_bytes = 5'd4;
      3'd3:    beat_bytes = 5'd8;
      default: beat_bytes = 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/dma_fifo.sv
module dma_fifo #(
  parameter int WIDTH = 129,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [PTR_W:0]   cnt_q;

  assign full_o  = (cnt_q == (PTR_W+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign rdata_o = mem_q[rptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (clear_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= (wptr_q == PTR_W'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
      if (pop_i)  rptr_q <= (rptr_q == PTR_W'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_q] <= wdata_i;
  end

  assert_no_push_full_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !clear_i |-> !push_i);
  assert_no_pop_empty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !pop_i);
  assert_count_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= (PTR_W+1)'(DEPTH));
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic              adv_i,
  input  logic              fixed_i,
  input  logic [4:0]        size_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                addr_o <= '0;
    else if (load_i)            addr_o <= start_i;
    else if (adv_i && !fixed_i) addr_o <= addr_o + ADDR_W'(size_i);
  end

  assert_fixed_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fixed_i && adv_i && !load_i |=> addr_o == $past(addr_o));
  assert_mem_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fixed_i && adv_i && !load_i |=> addr_o == $past(addr_o) + ADDR_W'($past(size_i)));
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 128,
  parameter int LEN_W      = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        csr_addr_i,
  input  logic              csr_wr_i,
  input  logic [31:0]       csr_wdata_i,
  output logic [31:0]       csr_rdata_o,
  output logic              irq_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              rd_read_o,
  input  logic              rd_waitreq_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_eop_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              wr_write_o,
  input  logic              wr_waitreq_i,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_eop_i
);
  localparam int FW = DATA_W + 1;

  logic [ADDR_W-1:0] src_q, dst_q;
  logic [LEN_W-1:0]  len_q, rd_rem_q, step_len;
  logic [2:0]        size_q;
  logic              irq_en_q, seop_en_q, deop_en_q, sfix_q, dfix_q;
  logic              busy_q, done_q, by_len_q, by_eop_q, rd_stop_q;
  logic [4:0]        size_b;

  logic              cfg_we, go, rd_acc, wr_acc, last_len, eop_hit, end_evt;
  logic              fifo_full, fifo_empty;
  logic [FW-1:0]     fifo_head;

  assign size_b   = beat_bytes(size_q);
  assign step_len = LEN_W'(size_b);
  assign cfg_we   = csr_wr_i && !busy_q;
  assign go       = cfg_we && (csr_addr_i == REG_CTRL) && csr_wdata_i[CB_GO];

  assign rd_read_o  = busy_q && !rd_stop_q && (rd_rem_q != '0) && !fifo_full;
  assign rd_acc     = rd_read_o && !rd_waitreq_i;
  assign wr_write_o = busy_q && !fifo_empty;
  assign wr_acc     = wr_write_o && !wr_waitreq_i;
  assign wr_data_o  = fifo_head[DATA_W-1:0];

  assign last_len = (len_q <= step_len);
  assign eop_hit  = fifo_head[DATA_W] || (deop_en_q && wr_eop_i);
  assign end_evt  = wr_acc && (last_len || eop_hit);
  assign irq_o    = done_q && irq_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0; dst_q <= '0; len_q <= '0; rd_rem_q <= '0; size_q <= '0;
      irq_en_q <= 1'b0; seop_en_q <= 1'b0; deop_en_q <= 1'b0;
      sfix_q <= 1'b0; dfix_q <= 1'b0;
      busy_q <= 1'b0; done_q <= 1'b0; by_len_q <= 1'b0; by_eop_q <= 1'b0;
      rd_stop_q <= 1'b0;
    end else begin
      if (cfg_we) begin
        case (csr_addr_i)
          REG_SRC:  src_q <= csr_wdata_i[ADDR_W-1:0];
          REG_DST:  dst_q <= csr_wdata_i[ADDR_W-1:0];
          REG_LEN:  len_q <= csr_wdata_i[LEN_W-1:0];
          REG_CTRL: begin
            size_q    <= csr_wdata_i[2:0];
            irq_en_q  <= csr_wdata_i[CB_IRQ];
            seop_en_q <= csr_wdata_i[CB_SEOP];
            deop_en_q <= csr_wdata_i[CB_DEOP];
            sfix_q    <= csr_wdata_i[CB_SFIX];
            dfix_q    <= csr_wdata_i[CB_DFIX];
          end
          default: ;
        endcase
      end
      if (csr_wr_i && csr_addr_i == REG_STATUS && csr_wdata_i[0]) done_q <= 1'b0;

      if (go) begin
        busy_q    <= (len_q != '0);
        done_q    <= (len_q == '0);
        by_len_q  <= (len_q == '0);
        by_eop_q  <= 1'b0;
        rd_rem_q  <= len_q;
        rd_stop_q <= 1'b0;
      end else if (end_evt) begin
        busy_q   <= 1'b0;
        done_q   <= 1'b1;
        by_len_q <= last_len;
        by_eop_q <= eop_hit;
      end

      if (wr_acc) len_q <= last_len ? '0 : len_q - step_len;
      if (rd_acc) begin
        rd_rem_q <= (rd_rem_q <= step_len) ? '0 : rd_rem_q - step_len;
        if (seop_en_q && rd_eop_i) rd_stop_q <= 1'b1;
      end
    end
  end

  always_comb begin
    case (csr_addr_i)
      REG_STATUS: csr_rdata_o = {28'd0, by_eop_q, by_len_q, busy_q, done_q};
      REG_SRC:    csr_rdata_o = 32'(src_q);
      REG_DST:    csr_rdata_o = 32'(dst_q);
      REG_LEN:    csr_rdata_o = 32'(len_q);
      REG_CTRL:   csr_rdata_o = {23'd0, dfix_q, sfix_q, deop_en_q, seop_en_q,
                                 irq_en_q, 1'b0, size_q};
      default:    csr_rdata_o = '0;
    endcase
  end

  dma_fifo #(.WIDTH(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .clear_i (go || end_evt),
    .push_i  (rd_acc),
    .wdata_i ({seop_en_q && rd_eop_i, rd_data_i}),
    .pop_i   (wr_acc),
    .rdata_o (fifo_head),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  dma_addr_gen #(.ADDR_W(ADDR_W)) u_src_addr (
    .clk_i, .rst_ni, .load_i(go), .start_i(src_q), .adv_i(rd_acc),
    .fixed_i(sfix_q), .size_i(size_b), .addr_o(rd_addr_o)
  );

  dma_addr_gen #(.ADDR_W(ADDR_W)) u_dst_addr (
    .clk_i, .rst_ni, .load_i(go), .start_i(dst_q), .adv_i(wr_acc),
    .fixed_i(dfix_q), .size_i(size_b), .addr_o(wr_addr_o)
  );

  assert_busy_end_done_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q);
  assert_start_nonzero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> rd_rem_q != '0 && fifo_empty);
  assert_len_nonincr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) |-> len_q <= $past(len_q));
  assert_no_read_after_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stop_q |-> !rd_read_o);
endmodule

// File: tb/sim_dma_engine.sv
module sim_dma_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;

  typedef struct packed {
    logic [2:0]  size;
    logic [31:0] src;
    logic [31:0] dst;
    logic [15:0] len;
    logic        sfix, dfix, seop_en, deop_en, irq_en, stall;
    logic [7:0]  seop_beat, deop_beat, exp_beats;
    logic        exp_eop;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{3'd2, 32'h100,  32'h2000, 16'd32, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'd0, 8'd0, 8'd8, 1'b0},
    '{3'd0, 32'h7F0,  32'h2100, 16'd5,  1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 8'd0, 8'd0, 8'd5, 1'b0},
    '{3'd4, 32'h1000, 32'h3000, 16'd64, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 8'd0, 8'd0, 8'd4, 1'b0},
    '{3'd1, 32'h200,  32'h2200, 16'd40, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'd3, 8'd0, 8'd3, 1'b1},
    '{3'd3, 32'h400,  32'h2400, 16'd80, 1'b0,1'b0,1'b0,1'b1,1'b1,1'b1, 8'd0, 8'd4, 8'd4, 1'b1},
    '{3'd2, 32'h600,  32'h2600, 16'd24, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'd2, 8'd3, 8'd6, 1'b0}
  };

  logic         clk_i = 1'b0, rst_ni = 1'b0;
  logic [2:0]   csr_addr_i = '0;
  logic         csr_wr_i = 1'b0;
  logic [31:0]  csr_wdata_i = '0;
  logic [31:0]  csr_rdata_o;
  logic         irq_o;
  logic [31:0]  rd_addr_o, wr_addr_o;
  logic         rd_read_o, wr_write_o, rd_waitreq_i, wr_waitreq_i, rd_eop_i, wr_eop_i;
  logic [127:0] rd_data_i, wr_data_o;

  logic         stall_en = 1'b0, clr_cnt = 1'b0;
  logic [7:0]   seop_beat = '0, deop_beat = '0;
  logic [15:0]  lfsr_q;
  int           rd_cnt, wr_cnt;
  logic [31:0]  log_addr [64];
  logic [127:0] log_data [64];
  int           n_chk = 0, n_fail = 0;

  dma_engine u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [127:0] pat(input logic [31:0] a);
    return {a + 32'd3, a + 32'd2, a + 32'd1, a ^ 32'h5A5A0000};
  endfunction

  assign rd_data_i    = pat(rd_addr_o);
  assign rd_waitreq_i = stall_en && lfsr_q[0];
  assign wr_waitreq_i = stall_en && lfsr_q[3];
  assign rd_eop_i     = (seop_beat != 0) && (rd_cnt == int'(seop_beat) - 1);
  assign wr_eop_i     = (deop_beat != 0) && (wr_cnt == int'(deop_beat) - 1);

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lfsr_q <= 16'hACE1; rd_cnt <= 0; wr_cnt <= 0;
    end else begin
      lfsr_q <= {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
      if (clr_cnt) begin
        rd_cnt <= 0; wr_cnt <= 0;
      end else begin
        if (rd_read_o && !rd_waitreq_i) rd_cnt <= rd_cnt + 1;
        if (wr_write_o && !wr_waitreq_i) begin
          if (wr_cnt < 64) begin
            log_addr[wr_cnt] <= wr_addr_o;
            log_data[wr_cnt] <= wr_data_o;
          end
          wr_cnt <= wr_cnt + 1;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    csr_addr_i = a; csr_wdata_i = d; csr_wr_i = 1'b1;
    @(negedge clk_i);
    csr_wr_i = 1'b0;
  endtask

  task automatic csr_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i);
    csr_addr_i = a;
    #1 d = csr_rdata_o;
  endtask

  task automatic reset_counts();
    @(negedge clk_i); clr_cnt = 1'b1;
    @(negedge clk_i); clr_cnt = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    logic [31:0] s;
    ok = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      csr_read(3'd0, s);
      if (s[0]) begin ok = 1'b1; break; end
    end
    if (!ok) chk("R11 timeout", 0, 1);
  endtask

  function automatic logic [31:0] ctrl_word(input vec_t v, input bit go);
    return {23'd0, v.dfix, v.sfix, v.deop_en, v.seop_en, v.irq_en, go, v.size};
  endfunction

  task automatic check_log(input vec_t v, input int n);
    bit bad = 1'b0;
    int sz = 1 << ((v.size > 3'd4) ? 4 : int'(v.size));
    for (int i = 0; i < n && i < 64; i++) begin
      logic [31:0] ea = v.dst + (v.dfix ? 32'd0 : 32'(i * sz));
      logic [31:0] sa = v.src + (v.sfix ? 32'd0 : 32'(i * sz));
      if (log_addr[i] !== ea || log_data[i] !== pat(sa)) begin
        bad = 1'b1;
        $display("FAIL R3 R4 R10 beat %0d actual=%0h/%0h expected=%0h/%0h",
                 i, log_addr[i], log_data[i], ea, pat(sa));
      end
    end
    n_chk++;
    if (bad) n_fail++;
  endtask

  task automatic run_vec(input vec_t v);
    logic [31:0] s;
    bit ok;
    int sz = 1 << int'(v.size);
    reset_counts();
    stall_en = v.stall; seop_beat = v.seop_beat; deop_beat = v.deop_beat;
    csr_write(3'd1, v.src);
    csr_write(3'd2, v.dst);
    csr_write(3'd3, {16'd0, v.len});
    csr_write(3'd4, ctrl_word(v, 1'b1));
    wait_done(ok);
    repeat (4) @(negedge clk_i);
    chk("R5 R6 R7 R8 beats", 128'(wr_cnt), 128'(v.exp_beats));
    check_log(v, wr_cnt);
    csr_read(3'd0, s);
    chk("R5 R6 R7 R11 status", 128'(s), v.exp_eop ? 128'h9 : 128'h5);
    csr_read(3'd3, s);
    chk("R5 length", 128'(s), 128'(v.exp_eop ? int'(v.len) - int'(v.exp_beats) * sz : 0));
    chk("R9 irq", 128'(irq_o), 128'(v.irq_en));
    csr_read(3'd4, s);
    chk("R2 ctrl readback", 128'(s), 128'(ctrl_word(v, 1'b0)));
    csr_write(3'd0, 32'h1);
    csr_read(3'd0, s);
    chk("R9 w1c", 128'({irq_o, s[0]}), 128'(0));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] s;
    bit ok;
    vec_t bv;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 outputs", 128'({irq_o, rd_read_o, wr_write_o}), 128'(0));
    for (int a = 0; a < 5; a++) begin
      csr_read(3'(a), s);
      chk("R1 register", 128'(s), 128'(0));
    end

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R12 zero length start
    reset_counts();
    stall_en = 1'b0; seop_beat = '0; deop_beat = '0;
    csr_write(3'd3, 32'd0);
    csr_write(3'd4, 32'h0000_001A);
    csr_read(3'd0, s);
    chk("R12 status", 128'(s), 128'h5);
    repeat (3) @(negedge clk_i);
    chk("R12 no bus", 128'({rd_cnt[7:0], wr_cnt[7:0]}), 128'(0));
    chk("R12 irq", 128'(irq_o), 128'(1));
    csr_write(3'd0, 32'h1);

    // R11 busy and writes ignored while busy
    bv = '{3'd2, 32'h300, 32'h4000, 16'd64, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,
           8'd0, 8'd0, 8'd16, 1'b0};
    reset_counts();
    stall_en = 1'b1;
    csr_write(3'd1, bv.src);
    csr_write(3'd2, bv.dst);
    csr_write(3'd3, 32'd64);
    csr_write(3'd4, ctrl_word(bv, 1'b1));
    csr_read(3'd0, s);
    chk("R11 busy", 128'(s[3:0]), 128'h2);
    csr_write(3'd3, 32'hFF);
    csr_write(3'd1, 32'hFFFF);
    csr_write(3'd4, 32'h0000_0188);
    csr_read(3'd3, s);
    chk("R11 len not overwritten", 128'(s <= 32'd64), 128'(1));
    wait_done(ok);
    repeat (4) @(negedge clk_i);
    chk("R11 beats", 128'(wr_cnt), 128'(16));
    check_log(bv, wr_cnt);
    csr_read(3'd1, s);
    chk("R11 src kept", 128'(s), 128'h300);
    csr_read(3'd4, s);
    chk("R11 ctrl kept", 128'(s), 128'(ctrl_word(bv, 1'b0)));
    csr_read(3'd0, s);
    chk("R11 R5 status", 128'(s), 128'h5);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule